// File: doc/BRIEF.md
# Sub-pel SAD vector unit

This unit speeds up the inner error loop of block motion estimation. Each operation takes a 128-bit vector of current-block pels and one, two or four 128-bit vectors of reference pels. It computes the sum of absolute differences between the current pels and a reference row. That reference row is either the pels as given, the rounded mean of two vectors (half-pel position) or the rounded mean of four vectors (diagonal half-pel position). The sum is added to a 32-bit scalar accumulator that comes in with the operation.

A caller presents an opcode, the operand vectors and the running accumulator together with a valid strobe. One cycle later the updated accumulator appears with a one-cycle done pulse. A new operation can be issued on every cycle. To add up one block, the caller feeds each result back in as the next accumulator input.

Top module: `sad_vec_unit`

## Requirements
- R1: Each vector holds 16 unsigned 8-bit pels, with pel i in bits 8i+7:8i. Opcode 2'b01 (plain) adds the sum over all pels of |cur − ref_a| to acc_in.
- R2: Opcode 2'b10 (half-pel) uses (ref_a + ref_b + 1) >> 1 as each reference pel. The rounding is exact, with no 8-bit overflow.
- R3: Opcode 2'b11 (diagonal) uses (ref_a + ref_b + ref_c + ref_d + 2) >> 2 as each reference pel. The rounding is exact, with no overflow.
- R4: The result is acc_in plus the SAD, taken modulo 2^32. No operation adds more than 16·255 = 4080.
- R5: acc_out and done are registered. done is high for exactly the cycle after a cycle in which op_valid was high, and in that cycle acc_out holds that operation's result. Operations may be issued on consecutive cycles.
- R6: Opcode 2'b00 is unrecognized. It gives acc_out = acc_in and still raises done.
- R7: While op_valid is low, done is low and acc_out holds its value. Operands that the opcode does not use (ref_b, ref_c and ref_d for plain; ref_c and ref_d for half-pel) have no effect on the result.
- R8: After reset, acc_out is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 none, 01 plain, 10 half-pel, 11 diagonal |
| cur_vec | input | 128 | Current-block pels |
| ref_a | input | 128 | Reference vector A |
| ref_b | input | 128 | Reference vector B |
| ref_c | input | 128 | Reference vector C |
| ref_d | input | 128 | Reference vector D |
| acc_in | input | 32 | Incoming accumulator |
| acc_out | output | 32 | Updated accumulator |
| done | output | 1 | One-cycle result pulse |

## Verification
The plain SAD is driven with all-equal vectors, which must give a zero sum. It is also driven with all-255 against all-zero vectors, which gives the largest sum; that sum is then added to an accumulator near 2^32 to expose missing wrap-around. The averaging modes get pel pairs and quads whose exact mean falls on .5 or .25. These tell correct round-half-up apart from truncation, and they show an overflowing 8-bit intermediate. A long run of back-to-back random operations in all four opcodes, with random unused operands, checks every cycle against a behavioural model. Idle gaps in that run show whether the result is held and done is quiet.

// File: rtl/sad_vec_pkg.sv
package sad_vec_pkg;
    typedef enum logic [1:0] {
        SV_OP_NONE = 2'b00,
        SV_OP_FULL = 2'b01,
        SV_OP_HALF = 2'b10,
        SV_OP_DIAG = 2'b11
    } sv_op_e;
endpackage

// File: rtl/sad_ref_interp.sv
module sad_ref_interp
    import sad_vec_pkg::*;
#(
    parameter int LANES = 16,
    parameter int PEL_W = 8
) (
    input  sv_op_e                   op,
    input  logic [LANES*PEL_W-1:0]   ref_a,
    input  logic [LANES*PEL_W-1:0]   ref_b,
    input  logic [LANES*PEL_W-1:0]   ref_c,
    input  logic [LANES*PEL_W-1:0]   ref_d,
    output logic [LANES*PEL_W-1:0]   ref_mix
);
    localparam int EXT_W = PEL_W + 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PEL_W-1:0] pa, pb, pc, pd;
        logic [EXT_W-1:0] sum2, sum4;
        assign pa = ref_a[i*PEL_W +: PEL_W];
        assign pb = ref_b[i*PEL_W +: PEL_W];
        assign pc = ref_c[i*PEL_W +: PEL_W];
        assign pd = ref_d[i*PEL_W +: PEL_W];
        assign sum2 = EXT_W'(pa) + EXT_W'(pb) + EXT_W'(1);
        assign sum4 = EXT_W'(pa) + EXT_W'(pb) + EXT_W'(pc) + EXT_W'(pd) + EXT_W'(2);

        always_comb begin
            case (op)
                SV_OP_HALF: ref_mix[i*PEL_W +: PEL_W] = sum2[PEL_W:1];
                SV_OP_DIAG: ref_mix[i*PEL_W +: PEL_W] = sum4[PEL_W+1:2];
                default:    ref_mix[i*PEL_W +: PEL_W] = pa;
            endcase
        end
    end
endmodule

// File: rtl/sad_lane_diff.sv
module sad_lane_diff #(
    parameter int LANES = 16,
    parameter int PEL_W = 8
) (
    input  logic [LANES*PEL_W-1:0] cur,
    input  logic [LANES*PEL_W-1:0] refv,
    output logic [LANES*PEL_W-1:0] absd
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PEL_W-1:0] c, r;
        assign c = cur[i*PEL_W +: PEL_W];
        assign r = refv[i*PEL_W +: PEL_W];
        assign absd[i*PEL_W +: PEL_W] = (c >= r) ? (c - r) : (r - c);
    end
endmodule

// File: rtl/sad_sum_tree.sv
module sad_sum_tree #(
    parameter int LANES = 16,
    parameter int PEL_W = 8,
    parameter int SUM_W = PEL_W + $clog2(LANES) + 1
) (
    input  logic [LANES*PEL_W-1:0] absd,
    output logic [SUM_W-1:0]       total
);
    localparam int LEVELS = $clog2(LANES);
    localparam int LEAVES = 1 << LEVELS;

    logic [SUM_W-1:0] node [2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < LANES) begin : g_used
            assign node[LEAVES-1+i] = SUM_W'(absd[i*PEL_W +: PEL_W]);
        end else begin : g_pad
            assign node[LEAVES-1+i] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES-1; n++) begin : g_node
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign total = node[0];
endmodule

// File: rtl/sad_vec_unit.sv
module sad_vec_unit
    import sad_vec_pkg::*;
#(
    parameter int LANES = 16,
    parameter int PEL_W = 8,
    parameter int ACC_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [1:0]             op_code,
    input  logic [LANES*PEL_W-1:0] cur_vec,
    input  logic [LANES*PEL_W-1:0] ref_a,
    input  logic [LANES*PEL_W-1:0] ref_b,
    input  logic [LANES*PEL_W-1:0] ref_c,
    input  logic [LANES*PEL_W-1:0] ref_d,
    input  logic [ACC_W-1:0]       acc_in,
    output logic [ACC_W-1:0]       acc_out,
    output logic                   done
);
    localparam int VEC_W   = LANES * PEL_W;
    localparam int SUM_W   = PEL_W + $clog2(LANES) + 1;
    localparam int MAX_SUM = LANES * ((1 << PEL_W) - 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             done;
    } state_t;

    sv_op_e           op;
    logic [VEC_W-1:0] ref_mix, absd;
    logic [SUM_W-1:0] total;
    state_t           st_d, st_q;

    assign op = sv_op_e'(op_code);

    sad_ref_interp #(.LANES(LANES), .PEL_W(PEL_W)) u_interp (
        .op(op), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .ref_d(ref_d),
        .ref_mix(ref_mix)
    );

    sad_lane_diff #(.LANES(LANES), .PEL_W(PEL_W)) u_diff (
        .cur(cur_vec), .refv(ref_mix), .absd(absd)
    );

    sad_sum_tree #(.LANES(LANES), .PEL_W(PEL_W), .SUM_W(SUM_W)) u_tree (
        .absd(absd), .total(total)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = op_valid;
        if (op_valid) begin
            if (op == SV_OP_NONE) st_d.acc = acc_in;
            else                  st_d.acc = acc_in + ACC_W'(total);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out = st_q.acc;
    assign done    = st_q.done;

    // R5
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    // R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!done && $stable(acc_out)));

    // R6
    unknown_op_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b00) |=> (acc_out == $past(acc_in)));

    // R4
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 2'b00) |=> ((acc_out - $past(acc_in)) <= ACC_W'(MAX_SUM)));

    // R1
    equal_vectors_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b01 && cur_vec == ref_a) |=> (acc_out == $past(acc_in)));
endmodule

// File: tb/sad_vec_unit_tb.sv
`timescale 1ns/1ps
module sad_vec_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'b00;
    logic [127:0] cur_vec = '0, ref_a = '0, ref_b = '0, ref_c = '0, ref_d = '0;
    logic [31:0]  acc_in = '0;
    logic [31:0]  acc_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] held;

    always #2.5 clk = ~clk;

    sad_vec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cur_vec(cur_vec), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .ref_d(ref_d),
        .acc_in(acc_in), .acc_out(acc_out), .done(done)
    );

    function automatic logic [31:0] model(input logic [1:0] op, input logic [127:0] c,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] cc,
            input logic [127:0] d, input logic [31:0] acc);
        int sum = 0;
        if (op == 2'b00) return acc;
        for (int i = 0; i < 16; i++) begin
            int pc = int'(c[i*8 +: 8]);
            int pa = int'(a[i*8 +: 8]);
            int pb = int'(b[i*8 +: 8]);
            int p3 = int'(cc[i*8 +: 8]);
            int p4 = int'(d[i*8 +: 8]);
            int r;
            if (op == 2'b01)      r = pa;
            else if (op == 2'b10) r = (pa + pb + 1) / 2;
            else                  r = (pa + pb + p3 + p4 + 2) / 4;
            sum += (pc > r) ? pc - r : r - pc;
        end
        return acc + 32'(sum);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input string tag, input logic [1:0] op, input logic [127:0] c,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] cc,
            input logic [127:0] d, input logic [31:0] acc);
        logic [31:0] exp = model(op, c, a, b, cc, d, acc);
        op_valid = 1'b1; op_code = op; cur_vec = c;
        ref_a = a; ref_b = b; ref_c = cc; ref_d = d; acc_in = acc;
        @(negedge clk);
        check({tag, " done"}, 32'(done), 32'd1);
        check(tag, acc_out, exp);
        held = acc_out;
    endtask

    task automatic idle(input string tag);
        op_valid = 1'b0;
        cur_vec = {$urandom, $urandom, $urandom, $urandom};
        ref_a = {$urandom, $urandom, $urandom, $urandom};
        acc_in = $urandom;
        @(negedge clk);
        check({tag, " done low"}, 32'(done), 32'd0);
        check({tag, " hold"}, acc_out, held);
    endtask

    function automatic logic [127:0] rv();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [127:0] fill(input logic [7:0] v);
        return {16{v}};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8
        check("R8 reset acc", acc_out, 32'd0);
        check("R8 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        held = acc_out;

        // R1: equal vectors, then extreme difference, then lane order
        issue("R1 equal", 2'b01, fill(8'h5A), fill(8'h5A), rv(), rv(), rv(), 32'd100);
        issue("R1 max", 2'b01, fill(8'hFF), fill(8'h00), '0, '0, '0, 32'd0);
        issue("R1 lanes", 2'b01, 128'h0F0E0D0C0B0A09080706050403020100, '0, rv(), rv(), rv(), 32'd7);
        // R7: unused operands ignored
        issue("R7 plain unused", 2'b01, fill(8'h10), fill(8'h20), fill(8'hFF), fill(8'hFF), fill(8'hFF), 32'd0);
        issue("R7 half unused", 2'b10, fill(8'h00), fill(8'h01), fill(8'h02), fill(8'hFF), fill(8'hFF), 32'd0);
        // R2: round half up (1,2 -> 2) and no overflow (255,255 -> 255)
        issue("R2 round", 2'b10, fill(8'h00), fill(8'h01), fill(8'h02), '0, '0, 32'd0);
        issue("R2 top", 2'b10, fill(8'hFF), fill(8'hFF), fill(8'hFF), '0, '0, 32'd0);
        // R3: (1,1,1,2)->1, (1,1,2,2)->2, all 255 -> 255
        issue("R3 quarter", 2'b11, fill(8'h00), fill(8'h01), fill(8'h01), fill(8'h01), fill(8'h02), 32'd0);
        issue("R3 half", 2'b11, fill(8'h00), fill(8'h01), fill(8'h01), fill(8'h02), fill(8'h02), 32'd0);
        issue("R3 top", 2'b11, fill(8'hFF), fill(8'hFF), fill(8'hFF), fill(8'hFF), fill(8'hFF), 32'd0);
        // R4: wrap
        issue("R4 wrap", 2'b01, fill(8'hFF), fill(8'h00), '0, '0, '0, 32'hFFFF_FFF0);
        // R6: unknown opcode
        issue("R6 pass", 2'b00, rv(), rv(), rv(), rv(), rv(), 32'hDEAD_BEEF);
        // R7: idle holds
        idle("R7 idle a");
        idle("R7 idle b");
        // R5: back-to-back random stream with gaps
        for (int n = 0; n < 200; n++) begin
            if (n % 17 == 16) idle("R7 gap");
            else issue("R5 stream", 2'($urandom), rv(), rv(), rv(), rv(), rv(), $urandom);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule